// File: doc/BRIEF.md
# Latched Dual-Group Interrupt Controller

This block gathers single-cycle event pulses from a metering datapath into two independent interrupt groups. The primary group serves the voltage channel and current channel A and also holds a reset-complete flag. The secondary group serves current channel B. Each group has three registers on a small register bus: an enable register, a status register and a reset-status alias. A read of the alias returns the status and then clears the whole group.

Status bits latch whenever their event fires, whether or not the bit is enabled. The primary group drives a dedicated active-low interrupt pin. The secondary group has no pin of its own. A 2-bit select input steers its active-low request onto one of three shared alternate output pins, or onto none of them.

The reset-complete flag is set on the first clock after reset is released. Its enable is on by default, so the host sees an interrupt as soon as the block is ready for it.

Top module: `irqc_top`

## Requirements
- R1: A status bit becomes 1 on the clock edge that samples its event input high, whatever the value of its enable bit.
- R2: `irq_n` is 0 while at least one primary status bit and the matching primary enable bit are both 1, and it is 1 otherwise.
- R3: A read of a status register returns the status in `bus_rdata` one cycle after the strobe, and it leaves every status bit unchanged.
- R4: A read of a reset-status alias returns the same value as the status register, one cycle after the strobe. On that same edge it clears every status bit of its group.
- R5: While reset is held, all enables are 0 except primary bit 20 (reset-complete), which is 1. All status bits are 0, `irq_n` = 1, `alt_n` = 3'b111 and `bus_rdata` = 0.
- R6: Primary status bit 20 (reset-complete) is set on the first clock edge after reset is released. Primary event input k maps to primary status bit k, for k from 0 to 19.
- R7: `alt_sel` = 0 drives no pin. The values 1, 2 and 3 select `alt_n[0]`, `alt_n[1]` and `alt_n[2]` respectively. The selected pin is 0 while any secondary status bit and its enable bit are both 1. Every unselected pin is held at 1.
- R8: A register is decoded only when `bus_addr[9:8]` is 2 or 3; both pages are aliases. The low byte selects the register: 0x2C primary enable, 0x2D primary status, 0x2E primary reset-status, 0x2F secondary enable, 0x30 secondary status, 0x31 secondary reset-status. Any other address reads 0 and ignores writes.
- R9: Writes to status and reset-status addresses change no state. Only the enable registers are writable.
- R10: If an event arrives in the same cycle as a reset-status read of its group, the event's status bit is 1 after the clear.
- R11: Reads are 32 bits wide, and unimplemented bits read 0. Enable writes keep only the implemented bits: 21 in the primary group and 9 in the secondary group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 10 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after `bus_rd` |
| pri_evt | input | 20 | Primary event pulses |
| sec_evt | input | 9 | Secondary event pulses |
| alt_sel | input | 2 | Secondary pin select (0 none, 1..3 pin index + 1) |
| irq_n | output | 1 | Primary interrupt, active low |
| alt_n | output | 3 | Alternate output pins, active low |

## Verification
The events are tried in several ways:
- An event with its enable off must latch silently, which separates status latching from pin gating.
- The same event after its enable is written shows the pin following the enable.
- An event in the same cycle as a reset-status read separates the rule that the event wins from a plain clear.

The four `alt_sel` values are stepped while a secondary request is pending, which shows that at most one pin ever goes low. Enables are written through one page and read back through the other, and also through an unmapped page, to show the aliasing and the width masking. A patterned stretch of mixed events, reads and clears is then compared with the bench model on every clock.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 10;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_PEN, SEL_PST, SEL_PRS, SEL_SEN, SEL_SST, SEL_SRS
  } regsel_e;

  // Page bits [9:8] must be 2 or 3; low byte picks the register.
  function automatic regsel_e decode_addr(input logic [ADDR_W-1:0] a);
    regsel_e r;
    r = SEL_NONE;
    if (a[9:8] == 2'd2 || a[9:8] == 2'd3) begin
      case (a[7:0])
        8'h2C:   r = SEL_PEN;
        8'h2D:   r = SEL_PST;
        8'h2E:   r = SEL_PRS;
        8'h2F:   r = SEL_SEN;
        8'h30:   r = SEL_SST;
        8'h31:   r = SEL_SRS;
        default: r = SEL_NONE;
      endcase
    end
    return r;
  endfunction

  // Pin idx (0-based) is driven when the select code equals idx+1.
  function automatic logic alt_pin_active(input logic [1:0] sel, input int idx,
                                          input logic req);
    return req && (int'(sel) == idx + 1);
  endfunction
endpackage

// File: rtl/irqc_group.sv
module irqc_group #(
  parameter int W = 8,
  parameter logic [W-1:0] EN_INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         en_wr,
  input  logic [W-1:0] en_wdata,
  input  logic         clr,
  output logic [W-1:0] status,
  output logic [W-1:0] enable,
  output logic         pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable <= EN_INIT;
      status <= '0;
    end else begin
      if (en_wr) enable <= en_wdata;
      // new events are ORed after the clear so none is lost
      status <= (clr ? '0 : status) | evt;
    end
  end

  assign pend = |(status & enable);
endmodule

// File: rtl/irqc_regbus.sv
module irqc_regbus #(
  parameter int PW = 21,
  parameter int SW = 9
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [irqc_pkg::ADDR_W-1:0]  bus_addr,
  input  logic                         bus_wr,
  input  logic                         bus_rd,
  output logic [irqc_pkg::DATA_W-1:0]  bus_rdata,
  input  logic [PW-1:0]                pst,
  input  logic [PW-1:0]                pen,
  input  logic [SW-1:0]                sst,
  input  logic [SW-1:0]                sen,
  output logic                         pen_wr,
  output logic                         sen_wr,
  output logic                         p_clr,
  output logic                         s_clr
);
  import irqc_pkg::*;

  regsel_e sel;
  logic [DATA_W-1:0] rmux;

  assign sel    = decode_addr(bus_addr);
  assign pen_wr = bus_wr && (sel == SEL_PEN);
  assign sen_wr = bus_wr && (sel == SEL_SEN);
  assign p_clr  = bus_rd && (sel == SEL_PRS);
  assign s_clr  = bus_rd && (sel == SEL_SRS);

  always_comb begin
    case (sel)
      SEL_PEN:          rmux = DATA_W'(pen);
      SEL_PST, SEL_PRS: rmux = DATA_W'(pst);
      SEL_SEN:          rmux = DATA_W'(sen);
      SEL_SST, SEL_SRS: rmux = DATA_W'(sst);
      default:          rmux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rmux;
  end
endmodule

// File: rtl/irqc_altmux.sv
module irqc_altmux #(
  parameter int NPIN = 3
) (
  input  logic [1:0]      alt_sel,
  input  logic            req,
  output logic [NPIN-1:0] alt_n
);
  import irqc_pkg::*;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    assign alt_n[i] = ~alt_pin_active(alt_sel, i, req);
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int PRI_EVT = 20,
  parameter int SEC_EVT = 9,
  parameter int NPIN    = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [9:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  input  logic        bus_rd,
  output logic [31:0] bus_rdata,
  input  logic [19:0] pri_evt,
  input  logic [8:0]  sec_evt,
  input  logic [1:0]  alt_sel,
  output logic        irq_n,
  output logic [2:0]  alt_n
);
  localparam int PRI_W = PRI_EVT + 1;
  localparam logic [PRI_W-1:0] PRI_EN_INIT = PRI_W'(1) << PRI_EVT;

  logic             boot_q;
  logic [PRI_W-1:0] pri_vec, pri_stat, pri_en;
  logic [SEC_EVT-1:0] sec_stat, sec_en;
  logic pri_pend, sec_pend, pen_wr, sen_wr, p_clr, s_clr;

  // one-shot reset-complete event on the first edge after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) boot_q <= 1'b1;
    else        boot_q <= 1'b0;
  end

  assign pri_vec = {boot_q, pri_evt};

  irqc_group #(.W(PRI_W), .EN_INIT(PRI_EN_INIT)) u_pri (
    .clk(clk), .rst_n(rst_n), .evt(pri_vec), .en_wr(pen_wr),
    .en_wdata(bus_wdata[PRI_W-1:0]), .clr(p_clr),
    .status(pri_stat), .enable(pri_en), .pend(pri_pend));

  irqc_group #(.W(SEC_EVT), .EN_INIT('0)) u_sec (
    .clk(clk), .rst_n(rst_n), .evt(sec_evt), .en_wr(sen_wr),
    .en_wdata(bus_wdata[SEC_EVT-1:0]), .clr(s_clr),
    .status(sec_stat), .enable(sec_en), .pend(sec_pend));

  irqc_regbus #(.PW(PRI_W), .SW(SEC_EVT)) u_bus (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .pst(pri_stat), .pen(pri_en),
    .sst(sec_stat), .sen(sec_en), .pen_wr(pen_wr), .sen_wr(sen_wr),
    .p_clr(p_clr), .s_clr(s_clr));

  irqc_altmux #(.NPIN(NPIN)) u_alt (
    .alt_sel(alt_sel), .req(sec_pend), .alt_n(alt_n));

  assign irq_n = ~pri_pend;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int PW = 21,
  parameter int SW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic [PW-1:0] pvec,
  input logic [PW-1:0] pst,
  input logic [PW-1:0] pen,
  input logic          p_clr,
  input logic          pen_wr,
  input logic [SW-1:0] sevt,
  input logic [SW-1:0] sst,
  input logic          s_clr,
  input logic [2:0]    alt_n
);
  // R1: every sampled event is latched on the next edge
  assert_evt_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|pvec) |=> ((pst & $past(pvec)) == $past(pvec)));

  // R3: without a reset-status read no status bit drops
  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !p_clr |=> ((pst & $past(pst)) == $past(pst)));

  // R4, R10: a clear leaves only the events of that same cycle
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    p_clr |=> (pst == $past(pvec)));

  assert_clear_sec_R10: assert property (@(posedge clk) disable iff (!rst_n)
    s_clr |=> (sst == $past(sevt)));

  // R9: enables move only on an enable write
  assert_en_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pen_wr |=> $stable(pen));

  // R7: never more than one alternate pin low
  assert_one_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~alt_n));
endmodule

bind irqc_top irqc_chk #(.PW(PRI_W), .SW(SEC_EVT)) u_chk (
  .clk(clk), .rst_n(rst_n), .pvec(pri_vec), .pst(pri_stat), .pen(pri_en),
  .p_clr(p_clr), .pen_wr(pen_wr), .sevt(sec_evt), .sst(sec_stat),
  .s_clr(s_clr), .alt_n(alt_n));

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
  logic        clk = 0, rst_n = 0;
  logic [9:0]  bus_addr = '0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [19:0] pri_evt = '0;
  logic [8:0]  sec_evt = '0;
  logic [1:0]  alt_sel = '0;
  logic        irq_n;
  logic [2:0]  alt_n;

  int total = 0, bad = 0;
  bit done = 0;

  // behavioural reference state
  logic [20:0] m_pen, m_pst;
  logic [8:0]  m_sen, m_sst;
  logic [31:0] m_rd;
  bit          m_boot;

  always #5 clk = ~clk;

  irqc_top dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int rmap(input logic [9:0] a);
    int lo;
    lo = int'(a[7:0]) - 'h2C;
    if ((a >> 8) < 2) return 0;
    if (lo < 0 || lo > 5) return 0;
    return lo + 1;
  endfunction

  task automatic model_reset();
    m_pen = 21'h100000; m_pst = '0; m_sen = '0; m_sst = '0;
    m_rd = '0; m_boot = 1;
  endtask

  task automatic model_step(input logic [9:0] a, input bit wr, input logic [31:0] wd,
                            input bit rd, input logic [19:0] pe, input logic [8:0] se);
    int r;
    logic [20:0] np;
    logic [8:0]  ns;
    r = rmap(a);
    if (rd) begin
      if (r == 1) m_rd = {11'd0, m_pen};
      else if (r == 2 || r == 3) m_rd = {11'd0, m_pst};
      else if (r == 4) m_rd = {23'd0, m_sen};
      else if (r == 5 || r == 6) m_rd = {23'd0, m_sst};
      else m_rd = 0;
    end
    np = (rd && r == 3) ? 21'd0 : m_pst;
    ns = (rd && r == 6) ? 9'd0 : m_sst;
    np = np | {m_boot, pe};
    ns = ns | se;
    m_boot = 0;
    if (wr && r == 1) m_pen = wd[20:0];
    if (wr && r == 4) m_sen = wd[8:0];
    m_pst = np;
    m_sst = ns;
  endtask

  // one clock: drive, advance, update model, compare every output
  task automatic cyc(input logic [9:0] a, input bit wr, input logic [31:0] wd,
                     input bit rd, input logic [19:0] pe, input logic [8:0] se);
    logic [2:0] ea;
    bus_addr = a; bus_wr = wr; bus_wdata = wd; bus_rd = rd;
    pri_evt = pe; sec_evt = se;
    @(posedge clk);
    model_step(a, wr, wd, rd, pe, se);
    #1;
    ea = 3'b111;
    if (|(m_sst & m_sen) && alt_sel != 0) ea[alt_sel - 1] = 1'b0;
    chk("R3/R4 rdata model", bus_rdata, m_rd);
    chk("R2 irq_n model", {31'd0, irq_n}, {31'd0, ~|(m_pst & m_pen)});
    chk("R7 alt_n model", {29'd0, alt_n}, {29'd0, ea});
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; pri_evt = '0; sec_evt = '0;
  endtask

  task automatic idle();       cyc(10'h0, 0, 0, 0, 0, 0); endtask
  task automatic rd(input logic [9:0] a);  cyc(a, 0, 0, 1, 0, 0); endtask
  task automatic wr(input logic [9:0] a, input logic [31:0] d); cyc(a, 1, d, 0, 0, 0); endtask

  initial begin
    #1_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    chk("R5 irq_n in reset", {31'd0, irq_n}, 32'd1);
    chk("R5 alt_n in reset", {29'd0, alt_n}, 32'd7);
    chk("R5 rdata in reset", bus_rdata, 32'd0);
    rst_n = 1;

    idle();
    chk("R6 reset-complete raises irq", {31'd0, irq_n}, 32'd0);
    rd(10'h22D);
    chk("R6 status bit 20", bus_rdata, 32'h0010_0000);
    chk("R3 status read keeps irq", {31'd0, irq_n}, 32'd0);
    rd(10'h22C);
    chk("R5 primary enable default", bus_rdata, 32'h0010_0000);
    rd(10'h22F);
    chk("R5 secondary enable default", bus_rdata, 32'd0);
    rd(10'h32E);
    chk("R4 reset-status value", bus_rdata, 32'h0010_0000);
    chk("R4 irq released", {31'd0, irq_n}, 32'd1);
    rd(10'h22D);
    chk("R4 status cleared", bus_rdata, 32'd0);

    cyc(10'h0, 0, 0, 0, 20'h8, 0);
    chk("R1 disabled event no irq", {31'd0, irq_n}, 32'd1);
    rd(10'h32D);
    chk("R1 disabled event latched", bus_rdata, 32'h8);
    wr(10'h32C, 32'h8);
    chk("R2 enable asserts irq", {31'd0, irq_n}, 32'd0);
    wr(10'h22D, 32'h0);
    wr(10'h22E, 32'h0);
    chk("R9 status write ignored irq", {31'd0, irq_n}, 32'd0);
    rd(10'h22D);
    chk("R9 status write ignored value", bus_rdata, 32'h8);

    cyc(10'h22E, 0, 0, 1, 20'h20, 0);
    chk("R10 clear read value", bus_rdata, 32'h8);
    rd(10'h22D);
    chk("R10 event survives clear", bus_rdata, 32'h20);
    chk("R2 unenabled bit no irq", {31'd0, irq_n}, 32'd1);

    alt_sel = 2'd0;
    wr(10'h22F, 32'h4);
    cyc(10'h0, 0, 0, 0, 0, 9'h4);
    chk("R7 select none", {29'd0, alt_n}, 32'd7);
    alt_sel = 2'd1; idle();
    chk("R7 pin 0", {29'd0, alt_n}, 32'h6);
    alt_sel = 2'd2; idle();
    chk("R7 pin 1", {29'd0, alt_n}, 32'h5);
    alt_sel = 2'd3; idle();
    chk("R7 pin 2", {29'd0, alt_n}, 32'h3);
    rd(10'h331);
    chk("R4 secondary clear value", bus_rdata, 32'h4);
    chk("R4 secondary pin released", {29'd0, alt_n}, 32'd7);

    rd(10'h12C);
    chk("R8 wrong page reads 0", bus_rdata, 32'd0);
    wr(10'h32F, 32'hFFFF_FFFF);
    rd(10'h22F);
    chk("R11 secondary width, R8 alias", bus_rdata, 32'h1FF);
    wr(10'h22C, 32'hFFFF_FFFF);
    rd(10'h32C);
    chk("R11 primary width", bus_rdata, 32'h1F_FFFF);
    wr(10'h12C, 32'h0);
    rd(10'h22C);
    chk("R8 unmapped write ignored", bus_rdata, 32'h1F_FFFF);

    // patterned mixed traffic, checked against the model every clock
    for (int i = 0; i < 60; i++) begin
      logic [9:0] a;
      case (i % 6)
        0: a = 10'h22D; 1: a = 10'h32E; 2: a = 10'h230;
        3: a = 10'h331; 4: a = 10'h22C; default: a = 10'h32F;
      endcase
      alt_sel = 2'(i % 4);
      cyc(a, (i % 6) >= 4 && (i % 5) == 0, 32'(i * 32'h1357), (i % 3) != 2,
          20'(1 << (i % 20)) & {20{i[0]}}, 9'(1 << (i % 9)) & {9{i[1]}});
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule